// File: doc/BRIEF.md
# Two-Vector External Interrupt Unit

This block turns external pins into interrupt requests for two vectors that a processor core services. Vector 1 is fed by one pin and can be set to latch edges or to follow the pin level. Vector 2 is fed by a group of port pins, each with its own enable bit. The enabled pins are merged onto one line before edge detection, so vector 2 only ever latches edges.

Every pin first passes through a synchronizer. A single polarity bit selects the active edge for both vectors. An edge-latched request stays pending until the core acknowledges the start of the matching service routine, and any number of edges during that time count as one request. A global enable gates delivery to the core. A separate wake output reports any pending or valid request, whatever the enable or the instruction-boundary strobe, so a stopped core can be released.

The merged line behaves as a wired gate: a pin held at the active level hides the edges of its neighbours. Changing the polarity bit, or enabling a pin that already sits at the active level, can latch a request with no pin edge at all. Both effects follow from the merge and are part of the intended behaviour.

Top module: `ext_irq_unit`

## Requirements
- R1: `irq1_req` and `irq2_req` are low whenever `glb_en` is 0. A pending request is kept while `glb_en` is 0 and appears as soon as `glb_en` returns to 1.
- R2: Pins pass through two flip-flops. A pin change made between clock edges sets the pending latch on the third rising edge after the change.
- R3: With `v1_level_mode`=1, `irq1_req` = `glb_en` AND `sample_stb` AND (synchronized `v1_pin` is 0). No vector 1 request is stored in this mode, so a low pulse that ends before a strobe raises nothing.
- R4: `edge_pol`=0 makes a falling edge active and `edge_pol`=1 makes a rising edge active. This holds for vector 2 and for vector 1 in edge mode (`v1_level_mode`=0), and edges of the other direction are ignored.
- R5: A pending latch clears on the rising edge where its `ack1`/`ack2` is high, unless a new edge arrives in that cycle. Several edges while a request is pending leave exactly one request.
- R6: If an acknowledge and a new active edge occur on the same rising edge, the latch stays set.
- R7: Vector 2 merges its enabled pins: an AND for falling mode and an OR for rising mode. A pin whose `v2_en` bit is 0 contributes the inactive level. An enabled pin held at the active level blocks edges from all other pins, and a disabled pin's edges are ignored.
- R8: Toggling `edge_pol` while the merged line is steady at the level that becomes active latches a request on the next rising edge.
- R9: Setting a `v2_en` bit while its synchronized pin already sits at the active level, with all other enabled pins inactive, latches a vector 2 request on the next rising edge.
- R10: `wake` is high when either latch is pending, or when level mode is selected and the synchronized `v1_pin` is 0. This does not depend on `glb_en` or `sample_stb`.
- R11: A synchronous active-high `rst` clears both pending latches, the synchronizers and the edge history. No request is present in the first cycle after reset, and steady idle pins latch nothing afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| v1_pin | input | 1 | Vector 1 interrupt pin |
| v2_pins | input | NPIN | Vector 2 interrupt pins |
| v2_en | input | NPIN | Per-pin interrupt enable for vector 2 |
| v1_level_mode | input | 1 | 1: vector 1 level-sensitive (active low), 0: edge |
| edge_pol | input | 1 | 0: falling edge active, 1: rising edge active |
| glb_en | input | 1 | Global interrupt enable |
| sample_stb | input | 1 | Instruction-boundary sample strobe |
| ack1 | input | 1 | Vector 1 service start pulse |
| ack2 | input | 1 | Vector 2 service start pulse |
| irq1_req | output | 1 | Vector 1 request to the core |
| irq2_req | output | 1 | Vector 2 request to the core |
| wake | output | 1 | Release from stop mode |

## Verification
The bench drives an acknowledge in exactly the cycle a new edge is detected. A latch that lets the clear win would drop that request, and the bench expects it still set. It holds one pin at the active level while another toggles, enables a pin that is already low, and flips the polarity with all pins high. A design that merged pins the wrong way or treated disabled pins as active would miss the masking or the spurious request. Level mode is probed with a short low pulse between strobes, which catches any design that stores the level, and `wake` is checked with the strobe and the global enable both low. Random traffic with random acknowledges and occasional resets is compared every cycle against a bench model.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    // Registered state of the interrupt unit (besides the synchronizer).
    typedef struct packed {
        logic hist1;   // previous normalized vector 1 line
        logic hist2;   // previous normalized vector 2 line
        logic pend1;   // vector 1 pending latch
        logic pend2;   // vector 2 pending latch
    } eirq_state_t;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/eirq_merge.sv
// Merges the enabled vector 2 pins onto one line and normalizes it so that
// the active edge is always a 1 -> 0 transition of 'norm'.
module eirq_merge #(
    parameter int NPIN = 8
) (
    input  logic [NPIN-1:0] pins,
    input  logic [NPIN-1:0] en,
    input  logic            pol,
    output logic            norm
);
    logic [NPIN-1:0] masked;
    logic            merged;

    for (genvar i = 0; i < NPIN; i++) begin : g_mask
        // a disabled pin drives the inactive level of the current polarity
        assign masked[i] = pol ? (pins[i] & en[i]) : (pins[i] | ~en[i]);
    end

    assign merged = pol ? (|masked) : (&masked);
    assign norm   = merged ^ pol;
endmodule

// File: rtl/eirq_pend.sv
// Next value of one pending latch: a new edge beats an acknowledge.
module eirq_pend (
    input  logic hist,
    input  logic norm,
    input  logic pend_q,
    input  logic ack,
    input  logic hold_off,
    output logic pend_d
);
    logic edge_hit;

    assign edge_hit = hist & ~norm;
    assign pend_d   = hold_off ? 1'b0 : (edge_hit | (pend_q & ~ack));
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
    import ext_irq_pkg::*;
#(
    parameter int NPIN        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            v1_pin,
    input  logic [NPIN-1:0] v2_pins,
    input  logic [NPIN-1:0] v2_en,
    input  logic            v1_level_mode,
    input  logic            edge_pol,
    input  logic            glb_en,
    input  logic            sample_stb,
    input  logic            ack1,
    input  logic            ack2,
    output logic            irq1_req,
    output logic            irq2_req,
    output logic            wake
);
    localparam int SW = NPIN + 1;

    eirq_state_t     st_d, st_q;
    logic [SW-1:0]   raw, synced;
    logic            v1_s;
    logic [NPIN-1:0] v2_s;
    logic            v1_norm, v2_norm;
    logic            pend1_nx, pend2_nx;
    logic            lvl_low;

    assign raw = {v2_pins, v1_pin};

    eirq_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    assign v1_s    = synced[0];
    assign v2_s    = synced[SW-1:1];
    assign v1_norm = v1_s ^ edge_pol;

    eirq_merge #(.NPIN(NPIN)) u_merge (
        .pins (v2_s),
        .en   (v2_en),
        .pol  (edge_pol),
        .norm (v2_norm)
    );

    eirq_pend u_pend1 (
        .hist     (st_q.hist1),
        .norm     (v1_norm),
        .pend_q   (st_q.pend1),
        .ack      (ack1),
        .hold_off (v1_level_mode),
        .pend_d   (pend1_nx)
    );

    eirq_pend u_pend2 (
        .hist     (st_q.hist2),
        .norm     (v2_norm),
        .pend_q   (st_q.pend2),
        .ack      (ack2),
        .hold_off (1'b0),
        .pend_d   (pend2_nx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.hist1 = v1_norm;
        st_d.hist2 = v2_norm;
        st_d.pend1 = pend1_nx;
        st_d.pend2 = pend2_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_low  = v1_level_mode & ~v1_s;
    assign irq1_req = glb_en & (v1_level_mode ? (sample_stb & ~v1_s) : st_q.pend1);
    assign irq2_req = glb_en & st_q.pend2;
    assign wake     = st_q.pend1 | st_q.pend2 | lvl_low;
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk (
    input logic clk,
    input logic rst,
    input logic glb_en,
    input logic v1_level_mode,
    input logic sample_stb,
    input logic ack2,
    input logic irq1_req,
    input logic irq2_req,
    input logic wake
);
    // R1
    gate_by_enable_chk: assert property (@(posedge clk) disable iff (rst)
        !glb_en |-> !(irq1_req || irq2_req));

    // R10
    wake_covers_req_chk: assert property (@(posedge clk) disable iff (rst)
        (irq1_req || irq2_req) |-> wake);

    // R5
    pend_held_chk: assert property (@(posedge clk) disable iff (rst)
        (irq2_req && !ack2) |=> (irq2_req || !glb_en));

    // R3
    level_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (v1_level_mode && !sample_stb) |-> !irq1_req);

    // R11
    clean_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq2_req);
endmodule

bind ext_irq_unit eirq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .glb_en        (glb_en),
    .v1_level_mode (v1_level_mode),
    .sample_stb    (sample_stb),
    .ack2          (ack2),
    .irq1_req      (irq1_req),
    .irq2_req      (irq2_req),
    .wake          (wake)
);

// File: tb/ext_irq_unit_test.sv
`timescale 1ns/1ps
module ext_irq_unit_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         v1_pin;
    logic [N-1:0] v2_pins, v2_en;
    logic         v1_level_mode, edge_pol, glb_en, sample_stb, ack1, ack2;
    logic         irq1_req, irq2_req, wake;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ext_irq_unit #(.NPIN(N)) uut (
        .clk(clk), .rst(rst), .v1_pin(v1_pin), .v2_pins(v2_pins), .v2_en(v2_en),
        .v1_level_mode(v1_level_mode), .edge_pol(edge_pol), .glb_en(glb_en),
        .sample_stb(sample_stb), .ack1(ack1), .ack2(ack2),
        .irq1_req(irq1_req), .irq2_req(irq2_req), .wake(wake)
    );

    // ---------------- bench model built from the requirements ----------------
    logic         m_a1, m_b1, m_h1, m_h2, m_p1, m_p2;
    logic [N-1:0] m_a2, m_b2;

    // R7: merged line, normalized so that the active edge is 1 -> 0
    function automatic logic line_norm(logic [N-1:0] p, logic [N-1:0] e, logic pol);
        logic all_hi = 1'b1;
        logic any_hi = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (e[i]) begin
                all_hi &= p[i];
                any_hi |= p[i];
            end
        end
        return pol ? ~any_hi : all_hi;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            {m_a1, m_b1, m_h1, m_h2, m_p1, m_p2} <= '0;
            m_a2 <= '0;
            m_b2 <= '0;
        end else begin
            m_a1 <= v1_pin;
            m_b1 <= m_a1;
            m_a2 <= v2_pins;
            m_b2 <= m_a2;
            m_h1 <= m_b1 ^ edge_pol;
            m_h2 <= line_norm(m_b2, v2_en, edge_pol);
            m_p1 <= v1_level_mode ? 1'b0 :
                    ((m_h1 & ~(m_b1 ^ edge_pol)) | (m_p1 & ~ack1));
            m_p2 <= (m_h2 & ~line_norm(m_b2, v2_en, edge_pol)) | (m_p2 & ~ack2);
        end
    end

    function automatic logic exp_irq1();
        return glb_en & (v1_level_mode ? (sample_stb & ~m_b1) : m_p1);
    endfunction
    function automatic logic exp_irq2();
        return glb_en & m_p2;
    endfunction
    function automatic logic exp_wake();
        return m_p1 | m_p2 | (v1_level_mode & ~m_b1);
    endfunction

    // ---------------- helpers ----------------
    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0b expected=%0b (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic pulse_ack(input logic a1, input logic a2);
        ack1 = a1;
        ack2 = a2;
        tick();
        ack1 = 1'b0;
        ack2 = 1'b0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            report();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        rst = 1'b1; v1_pin = 1'b1; v2_pins = '1; v2_en = '1;
        v1_level_mode = 1'b0; edge_pol = 1'b0; glb_en = 1'b1;
        sample_stb = 1'b0; ack1 = 1'b0; ack2 = 1'b0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11: reset state and idle pins after reset
        chk(irq1_req, 1'b0, "R11 irq1 after reset");
        chk(irq2_req, 1'b0, "R11 irq2 after reset");
        chk(wake,     1'b0, "R11 wake after reset");
        tick(4);
        chk(irq2_req, 1'b0, "R11 no spurious on idle pins");

        // R2 / R4: falling edge on pin 3, latency of three edges
        v2_pins[3] = 1'b0;
        tick(); chk(irq2_req, 1'b0, "R2 edge 1");
        tick(); chk(irq2_req, 1'b0, "R2 edge 2");
        tick(); chk(irq2_req, 1'b1, "R2 edge 3");

        // R5: more edges while pending collapse into one request
        v2_pins[3] = 1'b1; tick(4);
        v2_pins[3] = 1'b0; tick(4);
        chk(irq2_req, 1'b1, "R5 still pending");
        pulse_ack(1'b0, 1'b1);
        chk(irq2_req, 1'b0, "R5 single request cleared");

        // R6: acknowledge in the cycle of a new edge
        v2_pins[3] = 1'b1; tick(4);
        v2_pins[3] = 1'b0; tick(3);
        chk(irq2_req, 1'b1, "R6 first request");
        v2_pins[3] = 1'b1; tick(4);
        v2_pins[3] = 1'b0; tick(2);
        pulse_ack(1'b0, 1'b1);
        chk(irq2_req, 1'b1, "R6 edge beats ack");
        pulse_ack(1'b0, 1'b1);
        chk(irq2_req, 1'b0, "R6 cleared afterwards");

        // R7: pin 3 stuck low masks pin 5
        v2_pins[5] = 1'b0; tick(4);
        chk(irq2_req, 1'b0, "R7 masked by stuck pin");
        v2_pins[5] = 1'b1; v2_pins[3] = 1'b1; tick(4);
        chk(irq2_req, 1'b0, "R7 release gives no edge");
        // R7: disabled pin is ignored
        v2_en[6] = 1'b0; v2_pins[6] = 1'b0; tick(4);
        chk(irq2_req, 1'b0, "R7 disabled pin ignored");

        // R9: enabling a pin that is already low
        v2_en[6] = 1'b1; tick();
        chk(irq2_req, 1'b1, "R9 enable at active level");
        pulse_ack(1'b0, 1'b1);
        chk(irq2_req, 1'b0, "R9 ack clears");
        v2_pins[6] = 1'b1; tick(4);

        // R8: polarity flip with all lines high
        edge_pol = 1'b1; tick();
        chk(irq2_req, 1'b1, "R8 spurious on vector 2");
        chk(irq1_req, 1'b1, "R8 spurious on vector 1");
        pulse_ack(1'b1, 1'b1);
        chk(irq1_req, 1'b0, "R5 ack1 clears");
        chk(irq2_req, 1'b0, "R5 ack2 clears");

        // R4: rising mode
        v2_pins = '0; tick(4);
        chk(irq2_req, 1'b0, "R4 falling ignored in rising mode");
        v2_pins[2] = 1'b1; tick(3);
        chk(irq2_req, 1'b1, "R4 rising edge vector 2");
        pulse_ack(1'b0, 1'b1);
        v1_pin = 1'b0; tick(4);
        chk(irq1_req, 1'b0, "R4 v1 falling ignored");
        v1_pin = 1'b1; tick(3);
        chk(irq1_req, 1'b1, "R4 v1 rising edge");
        pulse_ack(1'b1, 1'b0);
        chk(irq1_req, 1'b0, "R5 v1 ack");

        // R1: pending held while globally disabled
        glb_en = 1'b0;
        v2_pins[2] = 1'b0; tick(4);
        v2_pins[2] = 1'b1; tick(3);
        chk(irq2_req, 1'b0, "R1 gated off");
        chk(wake,     1'b1, "R10 wake while disabled");
        glb_en = 1'b1; tick();
        chk(irq2_req, 1'b1, "R1 delivered after enable");
        pulse_ack(1'b0, 1'b1);
        chk(wake, 1'b0, "R10 wake drops");

        // R3: level mode on vector 1
        v1_level_mode = 1'b1; edge_pol = 1'b0; v2_pins = '1; tick(4);
        v1_pin = 1'b0; tick(2);
        chk(irq1_req, 1'b0, "R3 no strobe no request");
        chk(wake,     1'b1, "R10 wake without strobe");
        sample_stb = 1'b1; tick();
        chk(irq1_req, 1'b1, "R3 low at strobe");
        sample_stb = 1'b0; v1_pin = 1'b1; tick(2);
        sample_stb = 1'b1; tick();
        chk(irq1_req, 1'b0, "R3 high at strobe");
        sample_stb = 1'b0;
        v1_pin = 1'b0; tick();
        v1_pin = 1'b1; tick(3);
        sample_stb = 1'b1; tick();
        chk(irq1_req, 1'b0, "R3 pulse not stored");
        sample_stb = 1'b0;

        // random phase against the bench model (R1, R10, R11 via resets)
        for (int it = 0; it < 4000; it++) begin
            @(negedge clk);
            if (!rst) begin
                chk(irq1_req, exp_irq1(), "R1 irq1 random");
                chk(irq2_req, exp_irq2(), "R1 irq2 random");
                chk(wake,     exp_wake(), "R10 wake random");
            end
            rst = ($urandom_range(499) == 0);
            if ($urandom_range(5) == 0) v1_pin = ~v1_pin;
            for (int p = 0; p < N; p++) begin
                if ($urandom_range(9) == 0) v2_pins[p] = ~v2_pins[p];
            end
            if ($urandom_range(39) == 0) v2_en[$urandom_range(N-1)] ^= 1'b1;
            if ($urandom_range(99) == 0) edge_pol = ~edge_pol;
            if ($urandom_range(149) == 0) v1_level_mode = ~v1_level_mode;
            glb_en     = ($urandom_range(7) != 0);
            sample_stb = $urandom_range(1);
            ack1       = ($urandom_range(7) == 0);
            ack2       = ($urandom_range(7) == 0);
        end
        report();
    end
endmodule